// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control and status words of a host bridge behind a simple word-wide register bus. Software reaches each word by a byte address; the word index is that address shifted right by two. Most words are plain storage that hand their value to the rest of the bridge. The exceptions are an interrupt enable mask, a live interrupt status word, and a configuration bit that requests a system reset.

Software never writes the interrupt enable mask directly. Writing a value to the enable-set word turns on the matching mask bits. Writing a value to the enable-clear word turns them off. The mask and the status word are read-only from the bus. The status word copies an input port on every clock.

A write that takes bit 2 of the general configuration word from 0 to 1 raises a reset request for one cycle. On reset every word takes a fixed power-on value.

Top module: `bridge_ctl_regs`

## Requirements
- R1: 28 words of 32 bits sit at byte offsets 0x00 through 0x6C. The word index is address bits [AW-1:2]. A write to a plain storage word is returned unchanged by a later read. Read data appears on `rd_data` one clock after the edge that samples `rd_en`.
- R2: A write of V to offset 0x30 stores V in that word and sets every bit of V in the enable mask at offset 0x38. The other mask bits are left as they were.
- R3: A write of V to offset 0x34 stores V in that word and clears every bit of V in the enable mask at offset 0x38. The other mask bits are left as they were.
- R4: Bus writes to offset 0x38 (enable mask) and offset 0x3C (status) have no effect. The status word holds `irq_status` as sampled at the previous clock edge.
- R5: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, drives `sys_reset_req` high for exactly one cycle, starting at the clock after the write. The written value is stored in every case. No pulse is issued when the stored bit 2 is already 1, or when the written bit 2 is 0.
- R6: After reset the words read as follows:
  - 0x00 = 0x00000C40
  - 0x04 = 0x00001384 (bits 2, 7, 8, 9 and 12 set)
  - 0x08 = 0x2BFF8010
  - 0x0C = 0x255E0091
  - 0x10 = 0x00006140
  - 0x1C = 0x000001FF
  - 0x20 = 0x000001FF
  - 0x68 = 0x00000008
  - 0x6C = 0x10000000
  - every other word reads 0, and `sys_reset_req` is low.
- R7: Only full-word accesses are valid. A write whose address bits [1:0] are not zero changes nothing, and a read at such an address returns 0. Writes to offsets 0x70 and above change nothing, and reads there return 0.
- R8: `rd_data` changes only on a clock edge where `rd_en` is high. It holds its value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_status | input | 32 | Interrupt status sampled each cycle |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench uses the default parameters: AW = 8 and 28 words. With these values the address space has only 64 word slots, so a sweep can cover every one of them. That includes the 36 slots above the register file.

The sweep first reads all 64 slots to check the reset values. It then writes a distinct pattern to each slot and reads all 64 back, comparing against a model of the store, set, clear and protection rules.

Separate passes walk a single bit through the set and clear aliases. Further passes cover the edge cases of the reset bit, unaligned addresses and the status input.

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs #(
  parameter int AW     = 8,
  parameter int NWORDS = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  input  logic [31:0]   irq_status,
  output logic          sys_reset_req
);
  localparam int IW       = $clog2(NWORDS);
  localparam int IX_GEN   = 1;
  localparam int IX_ENSET = 12;
  localparam int IX_ENCLR = 13;
  localparam int IX_EN    = 14;
  localparam int IX_STAT  = 15;
  localparam int RST_BIT  = 2;

  function automatic logic [31:0] por_value(input int i);
    case (i)
      0:       por_value = 32'h0000_0C40;
      1:       por_value = 32'h0000_1384;
      2:       por_value = 32'h2BFF_8010;
      3:       por_value = 32'h255E_0091;
      4:       por_value = 32'h0000_6140;
      7, 8:    por_value = 32'h0000_01FF;
      26:      por_value = 32'h0000_0008;
      27:      por_value = 32'h1000_0000;
      default: por_value = 32'h0;
    endcase
  endfunction

  logic [NWORDS-1:0][31:0] regs;
  logic [31:0] widx;
  logic        aligned, hit, wr_ok;

  assign widx    = {{(34-AW){1'b0}}, addr[AW-1:2]};
  assign aligned = (addr[1:0] == 2'b00);
  assign hit     = aligned && (widx < NWORDS);
  assign wr_ok   = wr_en && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= por_value(i);
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (i == IX_STAT) begin
          regs[i] <= irq_status;
        end else if (i == IX_EN) begin
          if (wr_ok && widx == IX_ENSET)      regs[i] <= regs[i] | wr_data;
          else if (wr_ok && widx == IX_ENCLR) regs[i] <= regs[i] & ~wr_data;
        end else if (wr_ok && widx == i) begin
          regs[i] <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sys_reset_req <= 1'b0;
    else            sys_reset_req <= wr_ok && (widx == IX_GEN) &&
                                     wr_data[RST_BIT] && !regs[IX_GEN][RST_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 32'h0;
    else if (rd_en) rd_data <= hit ? regs[widx[IW-1:0]] : 32'h0;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ($past(wr_en) && $past(addr) == 4 && $past(wr_data[RST_BIT]))); // R5
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h30) |=> ((regs[IX_EN] & $past(wr_data)) == $past(wr_data))); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h34) |=> ((regs[IX_EN] & $past(wr_data)) == 32'h0)); // R3
  AST_EN_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h38) |=> $stable(regs[IX_EN])); // R4
  AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (regs[IX_STAT] == $past(irq_status))); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
endmodule

// File: tb/bridge_ctl_regs_test.sv
module bridge_ctl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NW = 28;
  localparam int SLOTS = 1 << (AW - 2);

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, irq_status = '0, rd_data;
  logic sys_reset_req;
  int tests = 0, fails = 0;
  logic [31:0] model [SLOTS];
  logic [31:0] got;

  bridge_ctl_regs #(.AW(AW), .NWORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_status(irq_status),
    .sys_reset_req(sys_reset_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] por(input int i);
    case (i)
      0: por = 32'hC40;        1: por = 32'h1384;
      2: por = 32'h2BFF8010;   3: por = 32'h255E0091;
      4: por = 32'h6140;       7: por = 32'h1FF;   8: por = 32'h1FF;
      26: por = 32'h8;         27: por = 32'h10000000;
      default: por = 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  function automatic void model_write(input int i, input logic [31:0] d);
    if (i >= NW) return;
    if (i == 12) begin model[12] = d; model[14] = model[14] | d; end
    else if (i == 13) begin model[13] = d; model[14] = model[14] & ~d; end
    else if (i != 14 && i != 15) model[i] = d;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset req", {31'b0, sys_reset_req}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < SLOTS; i++) begin
      bus_rd(AW'(i*4), got);
      check(i < NW ? "R6 default" : "R7 unmapped default", got, i < NW ? por(i) : 32'h0);
    end
    // R1 R2 R3 R4 R7 full sweep of every word slot
    irq_status = 32'h0F0F_1234;
    for (int i = 0; i < SLOTS; i++) model[i] = i < NW ? por(i) : 32'h0;
    for (int i = 0; i < SLOTS; i++) begin
      logic [31:0] p;
      p = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'h0000_0004;
      if (i == 12) p = 32'hF0F0_00FF;
      if (i == 13) p = 32'h3000_000F;
      bus_wr(AW'(i*4), p);
      model_write(i, p);
    end
    model[15] = irq_status;
    for (int i = 0; i < SLOTS; i++) begin
      bus_rd(AW'(i*4), got);
      check(i >= NW ? "R7 unmapped" : (i == 14 ? "R2 R3 mask" : (i == 15 ? "R4 status" : "R1 store")),
            got, i < NW ? model[i] : 32'h0);
    end
    // R2 R3 walking bit through set and clear aliases
    bus_wr(8'h34, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      bus_wr(8'h30, 32'h1 << k);
      bus_rd(8'h38, got);
      check("R2 set walk", got, (k == 31) ? 32'hFFFF_FFFF : ((32'h1 << (k+1)) - 1));
    end
    for (int k = 0; k < 32; k++) begin
      bus_wr(8'h34, 32'h1 << k);
      bus_rd(8'h38, got);
      check("R3 clear walk", got, (k == 31) ? 32'h0 : ~((32'h1 << (k+1)) - 1));
    end
    bus_rd(8'h34, got); check("R3 alias stored", got, 32'h8000_0000);
    bus_wr(8'h30, 32'h00F0_0F00);
    bus_wr(8'h38, 32'hFFFF_FFFF);
    bus_rd(8'h38, got); check("R4 mask protected", got, 32'h00F0_0F00);
    // R4 status follows input, ignores writes
    for (int k = 0; k < 4; k++) begin
      irq_status = 32'h1357_9BDF ^ (32'(k) << (k*8));
      bus_wr(8'h3C, 32'hDEAD_BEEF);
      bus_rd(8'h3C, got); check("R4 status", got, irq_status);
    end
    // R5 reset request
    bus_wr(8'h04, 32'h0000_0000);
    check("R5 no pulse on clear", {31'b0, sys_reset_req}, 32'h0);
    bus_wr(8'h04, 32'h0000_0004);
    check("R5 pulse on rise", {31'b0, sys_reset_req}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, sys_reset_req}, 32'h0);
    bus_wr(8'h04, 32'h0000_0104);
    check("R5 no pulse when set", {31'b0, sys_reset_req}, 32'h0);
    bus_rd(8'h04, got); check("R5 value stored", got, 32'h0000_0104);
    // R7 unaligned
    bus_wr(8'h40, 32'h1111_2222);
    for (int j = 1; j < 4; j++) begin
      bus_wr(AW'(8'h40 + j), 32'h9999_0000 + 32'(j));
      bus_rd(AW'(8'h40 + j), got); check("R7 unaligned read", got, 32'h0);
    end
    bus_rd(8'h40, got); check("R7 unaligned write", got, 32'h1111_2222);
    // R8 hold
    bus_rd(8'h08, got);
    irq_status = 32'h0;
    repeat (3) @(negedge clk);
    check("R8 hold", rd_data, got);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule